// File: doc/BRIEF.md
# Three-Phase Fundamental Bin Detector with Rotating Spare

This block tracks the line-frequency (bin 1) complex spectral value of three load-current sample streams. It also produces a compensation reference for each phase: the sample minus a scaled sine that is locked to the line voltage. Each bin comes from a recursive single-bin sliding DFT. A recursion of that kind collects rounding error for as long as it runs. To bound that error, the block holds four identical engines and uses only three of them at any time.

The fourth engine is a spare. While the other three serve the phases, the spare sits cleared. For one line period it is fed the samples of the phase it is about to take over. At the next period tick it replaces that phase's engine, and the engine it displaced is cleared in turn. The displaced engine is then refilled and swapped back, so every engine is reset regularly. A scheduler walks twelve states and counts line-period ticks to do this.

Samples enter on a plain strobe and results leave as a valid-qualified beat. The input is always accepted and the output carries no ready, so there is no back-pressure. A consumer must take each beat in the cycle it appears. The bin and reference outputs hold their value between beats.

Top module: `fdet_top`

## Requirements
- R1: After reset, `out_valid` is low and every `bin_re`, `bin_im` and `ref_cur` lane reads zero. The scheduler starts in the first run state, with all three phases on their own engines.
- R2: Each cycle with `smp_valid` high produces exactly one `out_valid` pulse, two clock cycles later. `out_valid` is never high otherwise.
- R3: Each engine updates on every accepted sample as S ← W·(S + x(n) − x(n−N)). Here W = (TW_C + j·TW_S)/2^16, each rotated part is rounded by adding 2^15 before the arithmetic shift, and the result saturates to AW bits. Once N samples have entered since a clear, a phase driven with a sinusoid of amplitude A and exactly N samples per period reads |bin| ≈ A·N/2.
- R4: A constant input drives its phase's bin to (near) zero once a full window of N samples has entered.
- R5: The scheduler has 12 states that alternate a run state of RUN_PER ticks with a warm-up state of one tick. Each rotation k (phase 0, then 1, then 2) uses four of these states. The first run state has the original assignment. In the warm-up that follows, engine 3 loads phase k. In the next run state, engine 3 serves phase k and engine k is cleared. In the second warm-up, engine k reloads phase k. The sequence then returns to the first state.
- R6: The engine that feeds a phase output changes only at a clock edge where `period_tick` is high.
- R7: The spare engine is held cleared in every run state. A clear empties both the bin and the sample window in one cycle.
- R8: Through a whole 12-state sequence, including every hot swap, each phase's bin magnitude stays at its correct value on every output beat.
- R9: `ref_cur[p]` = x_p − floor(amp[p]·s/2^16), where s is round(2^16·sin(2π·ph/N)) taken from a quarter-wave table. `amp` is read as unsigned.
- R10: The sine index ph of a sample is 0 when `zero_cross` is high with that sample. Otherwise it is the previous index plus one, modulo N. The first sample after reset takes index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Sample strobe, one cycle per sample set |
| smp_data | input | 3×SW | Signed load-current sample per phase |
| period_tick | input | 1 | One-cycle pulse at each line-period boundary |
| zero_cross | input | 1 | Rising zero-crossing of line voltage, given with a strobe |
| amp | input | 3×SW | Unsigned fundamental amplitude per phase for the reference |
| out_valid | output | 1 | Result beat valid |
| bin_re | output | 3×AW | Signed real part of the bin per phase |
| bin_im | output | 3×AW | Signed imaginary part of the bin per phase |
| ref_cur | output | 3×(SW+2) | Signed compensation reference per phase |

## Verification
The assertions take for granted that `period_tick` falls between samples after exactly N strobes, and never in the cycle of a strobe. They also assume `zero_cross` only rises together with a strobe. Under these conditions a warmed-up spare holds the full window at the moment it is swapped in. The bench spaces every strobe several cycles apart. It raises the tick alone, one cycle after the check of every Nth sample. It drives `zero_cross` only inside the strobe cycle, so the scheduler and the sine index see inputs that meet these conditions.

// File: rtl/fdet_pkg.sv
package fdet_pkg;
  localparam int NPH    = 3;
  localparam int NENG   = 4;
  localparam int NSTATE = 12;
  localparam int TWW    = 18;
  localparam int FRAC   = 16;

  // Scheduler state decoded: rotation phase, swapped flag, warm-up flag.
  typedef struct packed {
    logic [1:0] rot;
    logic       swapped;
    logic       warm;
  } route_t;
endpackage

// File: rtl/fdet_sched.sv
module fdet_sched
  import fdet_pkg::*;
#(
  parameter int RUN_PER = 8,
  localparam int CNTW = $clog2(RUN_PER + 1)
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  output route_t route
);
  logic [3:0]      idx;
  logic [CNTW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
      cnt <= '0;
    end else if (tick) begin
      if (idx[0] || cnt == CNTW'(RUN_PER - 1)) begin
        cnt <= '0;
        idx <= (idx == 4'(NSTATE - 1)) ? 4'd0 : idx + 4'd1;
      end else begin
        cnt <= cnt + CNTW'(1);
      end
    end
  end

  assign route = route_t'(idx);

  AST_SRC_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(idx) |-> $past(tick)); // R6
  AST_STATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx < 4'(NSTATE)); // R5
  AST_WARM_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && idx[0]) |=> !idx[0]); // R5
endmodule

// File: rtl/fdet_bin.sv
module fdet_bin
  import fdet_pkg::*;
#(
  parameter int N    = 16,
  parameter int SW   = 12,
  parameter int AW   = 20,
  parameter int TW_C = 60547,
  parameter int TW_S = 25080
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 upd,
  input  logic signed [SW-1:0] x,
  output logic signed [AW-1:0] bin_re,
  output logic signed [AW-1:0] bin_im
);
  localparam int PTW = $clog2(N);
  localparam int FLW = $clog2(N + 1);
  localparam int VW  = AW + 2;
  localparam int MW  = VW + TWW + 1;
  localparam logic signed [MW-1:0] SMAX = MW'((longint'(1) <<< (AW - 1)) - 1);
  localparam logic signed [MW-1:0] SMIN = -SMAX - MW'(1);
  localparam logic signed [MW-1:0] HALF = MW'(1 <<< (FRAC - 1));
  localparam logic signed [TWW-1:0] WC = TWW'(TW_C);
  localparam logic signed [TWW-1:0] WS = TWW'(TW_S);

  logic signed [SW-1:0] hist [N];
  logic [PTW-1:0]       ptr;
  logic [FLW-1:0]       fill;
  logic signed [SW-1:0] x_old;
  logic signed [VW-1:0] v_re, v_im;
  logic signed [MW-1:0] p_re, p_im, r_re, r_im;
  logic signed [AW-1:0] n_re, n_im;

  always_comb begin
    // Window entries only count once the fill counter says they were written.
    x_old = (fill == FLW'(N)) ? hist[ptr] : '0;
    v_re  = bin_re + x - x_old;
    v_im  = bin_im;
    p_re  = WC * v_re - WS * v_im;
    p_im  = WS * v_re + WC * v_im;
    r_re  = (p_re + HALF) >>> FRAC;
    r_im  = (p_im + HALF) >>> FRAC;
    n_re  = (r_re > SMAX) ? AW'(SMAX) : (r_re < SMIN) ? AW'(SMIN) : AW'(r_re);
    n_im  = (r_im > SMAX) ? AW'(SMAX) : (r_im < SMIN) ? AW'(SMIN) : AW'(r_im);
  end

  always_ff @(posedge clk) begin
    if (upd && !clr) hist[ptr] <= x;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0; fill <= '0; bin_re <= '0; bin_im <= '0;
    end else if (clr) begin
      ptr <= '0; fill <= '0; bin_re <= '0; bin_im <= '0;
    end else if (upd) begin
      ptr    <= (ptr == PTW'(N - 1)) ? '0 : ptr + PTW'(1);
      fill   <= (fill == FLW'(N)) ? fill : fill + FLW'(1);
      bin_re <= n_re;
      bin_im <= n_im;
    end
  end

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (bin_re == '0 && bin_im == '0 && fill == '0)); // R7
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FLW'(N)); // R3
endmodule

// File: rtl/fdet_sine.sv
module fdet_sine
  import fdet_pkg::*;
#(
  parameter int N = 16,
  parameter logic [(N/4+1)*TWW-1:0] SIN_QTR = {18'd65536, 18'd60547, 18'd46341, 18'd25080, 18'd0}
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  smp_valid,
  input  logic                  zero_cross,
  output logic signed [TWW-1:0] sinq
);
  localparam int PHW = $clog2(N);
  localparam int Q   = N / 4;
  localparam int QB  = $clog2(Q);
  localparam int TIW = QB + 1;

  logic [PHW-1:0]        ph;
  logic [1:0]            quad;
  logic [TIW-1:0]        tix;
  logic signed [TWW-1:0] mag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ph <= PHW'(N - 1);
    else if (smp_valid) ph <= zero_cross ? '0 : ph + PHW'(1);
  end

  always_comb begin
    quad = ph[PHW-1 -: 2];
    tix  = quad[0] ? TIW'(Q) - TIW'(ph[QB-1:0]) : TIW'(ph[QB-1:0]);
    mag  = SIN_QTR[tix*TWW +: TWW];
    sinq = quad[1] ? -mag : mag;
  end

  AST_ZC_PHASE0: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && zero_cross) |=> (ph == '0)); // R10
endmodule

// File: rtl/fdet_top.sv
module fdet_top
  import fdet_pkg::*;
#(
  parameter int N       = 16,
  parameter int SW      = 12,
  parameter int RUN_PER = 8,
  parameter int TW_C    = 60547,
  parameter int TW_S    = 25080,
  parameter logic [(N/4+1)*TWW-1:0] SIN_QTR = {18'd65536, 18'd60547, 18'd46341, 18'd25080, 18'd0},
  localparam int AW   = SW + 8,
  localparam int REFW = SW + 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      smp_valid,
  input  logic [NPH-1:0][SW-1:0]    smp_data,
  input  logic                      period_tick,
  input  logic                      zero_cross,
  input  logic [NPH-1:0][SW-1:0]    amp,
  output logic                      out_valid,
  output logic [NPH-1:0][AW-1:0]    bin_re,
  output logic [NPH-1:0][AW-1:0]    bin_im,
  output logic [NPH-1:0][REFW-1:0]  ref_cur
);
  localparam int PRW = SW + TWW + 1;

  route_t                route;
  logic signed [SW-1:0]  smp_s   [NPH];
  logic signed [SW-1:0]  x_d     [NPH];
  logic signed [AW-1:0]  eng_re  [NENG];
  logic signed [AW-1:0]  eng_im  [NENG];
  logic signed [AW-1:0]  src_re  [NPH];
  logic signed [AW-1:0]  src_im  [NPH];
  logic signed [REFW-1:0] ref_n  [NPH];
  logic signed [AW-1:0]  spare_re, spare_im;
  logic signed [TWW-1:0] sinq;
  logic                  vld_d;

  fdet_sched #(.RUN_PER(RUN_PER)) sched_i (
    .clk(clk), .rst_n(rst_n), .tick(period_tick), .route(route)
  );

  fdet_sine #(.N(N), .SIN_QTR(SIN_QTR)) sine_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .zero_cross(zero_cross), .sinq(sinq)
  );

  always_comb begin
    for (int p = 0; p < NPH; p++) smp_s[p] = smp_data[p];
  end

  // Engines 0..2 always load their own phase; engine 3 loads the phase being rotated.
  for (genvar e = 0; e < NENG; e++) begin : g_eng
    logic                 is_spare;
    logic                 hold_clr;
    logic signed [SW-1:0] xin;
    always_comb begin
      is_spare = (e == NENG - 1) ? !route.swapped : (route.swapped && route.rot == 2'(e));
      hold_clr = is_spare && !route.warm;
      xin      = (e == NENG - 1) ? smp_s[route.rot] : smp_s[e];
    end
    fdet_bin #(.N(N), .SW(SW), .AW(AW), .TW_C(TW_C), .TW_S(TW_S)) bin_i (
      .clk(clk), .rst_n(rst_n), .clr(hold_clr), .upd(smp_valid && !hold_clr),
      .x(xin), .bin_re(eng_re[e]), .bin_im(eng_im[e])
    );
  end

  always_comb begin
    for (int p = 0; p < NPH; p++) begin
      if (route.swapped && route.rot == 2'(p)) begin
        src_re[p] = eng_re[NENG-1];
        src_im[p] = eng_im[NENG-1];
      end else begin
        src_re[p] = eng_re[p];
        src_im[p] = eng_im[p];
      end
    end
    spare_re = route.swapped ? eng_re[route.rot] : eng_re[NENG-1];
    spare_im = route.swapped ? eng_im[route.rot] : eng_im[NENG-1];
  end

  for (genvar p = 0; p < NPH; p++) begin : g_ref
    logic signed [PRW-1:0] prod, scaled;
    always_comb begin
      prod     = $signed({1'b0, amp[p]}) * sinq;
      scaled   = prod >>> FRAC;
      ref_n[p] = REFW'(x_d[p] - scaled);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_d     <= 1'b0;
      out_valid <= 1'b0;
      bin_re    <= '0;
      bin_im    <= '0;
      ref_cur   <= '0;
      for (int p = 0; p < NPH; p++) x_d[p] <= '0;
    end else begin
      vld_d     <= smp_valid;
      out_valid <= vld_d;
      if (smp_valid) begin
        for (int p = 0; p < NPH; p++) x_d[p] <= smp_s[p];
      end
      if (vld_d) begin
        for (int p = 0; p < NPH; p++) begin
          bin_re[p]  <= src_re[p];
          bin_im[p]  <= src_im[p];
          ref_cur[p] <= ref_n[p];
        end
      end
    end
  end

  AST_OUT_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(smp_valid, 2)); // R2
  AST_SPARE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!route.warm && $stable(route)) |-> (spare_re == '0 && spare_im == '0)); // R7
endmodule

// File: tb/fdet_top_tb_top.sv
`timescale 1ns/1ps
module fdet_top_tb_top;
  localparam int N = 16;
  localparam int SW = 12;
  localparam int AW = SW + 8;
  localparam int REFW = SW + 2;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic period_tick = 1'b0;
  logic zero_cross = 1'b0;
  logic [2:0][SW-1:0] smp_data = '0;
  logic [2:0][SW-1:0] amp = '0;
  logic out_valid;
  logic [2:0][AW-1:0] bin_re, bin_im;
  logic [2:0][REFW-1:0] ref_cur;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  fdet_top dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .period_tick(period_tick), .zero_cross(zero_cross), .amp(amp),
    .out_valid(out_valid), .bin_re(bin_re), .bin_im(bin_im), .ref_cur(ref_cur)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic real magn(input int p);
    real re, im;
    re = $itor($signed(bin_re[p]));
    im = $itor($signed(bin_im[p]));
    return $sqrt(re * re + im * im);
  endfunction

  function automatic int sin_model(input int ph);
    real v;
    v = 65536.0 * $sin(2.0 * PI * ph / N);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    smp_valid = 1'b0;
    period_tick = 1'b0;
    zero_cross = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // One sample: strobe, confirm no early beat, confirm the beat two cycles on.
  task automatic step(input int x0, input int x1, input int x2, input bit zc, input bit tk);
    @(negedge clk);
    smp_valid = 1'b1;
    zero_cross = zc;
    smp_data[0] = SW'(x0);
    smp_data[1] = SW'(x1);
    smp_data[2] = SW'(x2);
    @(negedge clk);
    smp_valid = 1'b0;
    zero_cross = 1'b0;
    chk(out_valid == 1'b0, "R2 early beat", longint'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R2 beat after two cycles", longint'(out_valid), 1);
    if (tk) begin
      period_tick = 1'b1;
      @(negedge clk);
      period_tick = 1'b0;
    end
  endtask

  task automatic test_reset();
    do_reset();
    chk(out_valid == 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);
    for (int p = 0; p < 3; p++) begin
      chk(bin_re[p] == '0 && bin_im[p] == '0, "R1 bins zero after reset",
          longint'($signed(bin_re[p])), 0);
      chk(ref_cur[p] == '0, "R1 reference zero after reset", longint'($signed(ref_cur[p])), 0);
    end
  endtask

  // Full 12-state rotation with a distinct sinusoid per phase.
  task automatic test_sine_rotation();
    int amps [3] = '{1000, 600, 1500};
    int xs [3];
    real expm, tol, m;
    do_reset();
    for (int n = 0; n < 56 * N; n++) begin
      for (int p = 0; p < 3; p++)
        xs[p] = $rtoi($floor(amps[p] * $sin(2.0 * PI * n / N + 2.0 * PI * p / 3.0) + 0.5));
      step(xs[0], xs[1], xs[2], 1'b0, (n % N) == N - 1);
      if (n >= N - 1) begin
        for (int p = 0; p < 3; p++) begin
          expm = amps[p] * N / 2.0;
          tol = 0.03 * expm + 16.0;
          m = magn(p);
          if (n < 2 * N)
            chk((m > expm - tol) && (m < expm + tol), "R3 sine bin magnitude",
                $rtoi(m), $rtoi(expm));
          else // R5/R6/R7/R8: routing, tick-aligned swaps, clean spare, continuity
            chk((m > expm - tol) && (m < expm + tol), "R8 magnitude through swaps (R5 R6 R7)",
                $rtoi(m), $rtoi(expm));
        end
      end
    end
  endtask

  task automatic test_dc();
    int lv [3] = '{500, -700, 1234};
    real m;
    do_reset();
    for (int n = 0; n < 3 * N; n++) begin
      step(lv[0], lv[1], lv[2], 1'b0, (n % N) == N - 1);
      if (n >= N - 1) begin
        for (int p = 0; p < 3; p++) begin
          m = magn(p);
          chk(m < 40.0, "R4 constant input bin near zero", $rtoi(m), 0);
        end
      end
    end
  endtask

  task automatic test_reference();
    int ph = N - 1;
    int xs [3];
    int av [3] = '{800, 1200, 400};
    bit zc;
    longint expv, sc;
    do_reset();
    for (int p = 0; p < 3; p++) amp[p] = SW'(av[p]);
    for (int n = 0; n < 40; n++) begin
      zc = (n == 3) || (n == 19) || (n == 26);
      ph = zc ? 0 : (ph + 1) % N;
      for (int p = 0; p < 3; p++) xs[p] = (n * 37 + p * 211) % 900 - 450;
      step(xs[0], xs[1], xs[2], zc, 1'b0);
      for (int p = 0; p < 3; p++) begin
        sc = (longint'(av[p]) * sin_model(ph)) >>> 16;
        expv = xs[p] - sc;
        chk(longint'($signed(ref_cur[p])) == expv, "R9 reference value (R10 sine index)",
            longint'($signed(ref_cur[p])), expv);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog expired act=%0d exp=%0d", 200000, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    test_reset();
    test_sine_rotation();
    test_dc();
    test_reference();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule